// File: doc/BRIEF.md
# Flag-Producing Multi-Function ALU

This block is a purely combinational 32-bit arithmetic and logic unit for a single-cycle processor datapath. One 5-bit function code routes operands A and B to one of four internal paths: a shared add/subtract unit, a two-operand bitwise logic unit, a bidirectional barrel shifter, or a less-than compare that reuses the subtractor. Alongside the result, it returns four condition flags: zero, overflow, carry and negative.

The function code is read as five named fields, from the most significant bit down: a subtract bit, a 2-bit operation selector, a shift-path bit and a math-path bit. The surrounding control logic produces this code. The control logic can then resolve branches from the flags alone, so no separate comparator is needed. The block has no clock and no state, so its outputs follow its inputs within the same cycle.

Top module: `flag_alu`

## Requirements
- R1: With code[1:0]=01 and code[4]=0, the result is A+B modulo 2^32. C is the carry out of bit 31. V is set when A and B have the same sign and the sum's sign differs from it (for example, code 5'b00001 with A=1 and B=32'hFFFFFFFF gives result 0 and C=1).
- R2: With code[1:0]=01 and code[4]=1 (code 5'b10001), the result is A+~B+1. C is the carry out of bit 31, so C=1 means no borrow. V is set when A and B differ in sign and the result's sign differs from A's.
- R3: With code[1:0]=00, code[3:2] selects a bitwise operation: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOR of A and B.
- R4: With code[1:0]=10, the result is B shifted by the amount in A[4:0]; bits A[31:5] are ignored. code[3:2]=00 or 01 shifts left with zero fill, 10 shifts right with zero fill, and 11 shifts right with copies of B[31].
- R5: With code[1:0]=11, the result is 1 in bit 0, with bits 31:1 zero, when A is less than B, and 0 otherwise. code[2]=1 compares A and B as signed values; code[2]=0 compares them as unsigned values.
- R6: Z is 1 exactly when all 32 result bits are 0.
- R7: N equals bit 31 of the result.
- R8: V and C are 0 whenever code[0]=0 (the logic and shift paths).
- R9: In compare mode, code[4] has no effect. The block always computes A−B, and V and C report that subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | Operand A; its low 5 bits give the shift amount |
| op_b_i | input | 32 | Operand B; the value shifted in shift mode |
| fn_i | input | 5 | Function code {subtract, operation select[1:0], shift path, math path} |
| res_o | output | 32 | Result |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry-out flag |
| n_o | output | 1 | Negative flag |

## Verification
Some properties are checked whenever the inputs settle:
- An operand subtracted from itself gives zero with carry set.
- Adding zero returns A unchanged.
- A zero shift amount passes B through.
- XOR of equal operands is zero.
- A compare result never uses bits 31:1.
- V and C stay low outside the math path.
- Z and N are never both set.

Only the bench's directed scenarios and its sweep against an independent reference model can show that the other functions are correct. These include the exact sums and their carry and overflow at sign and wrap boundaries, each shift kind and how it fills, that A[31:5] is ignored, the signed-versus-unsigned compare split, and that the subtract bit has no effect in compare mode.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shft;
    logic       math;
  } alu_fn_t;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_XOR = 2'b10,
    LOG_NOR = 2'b11
  } log_op_e;

  typedef enum logic [1:0] {
    PATH_LOGIC = 2'b00,
    PATH_ADDER = 2'b01,
    PATH_SHIFT = 2'b10,
    PATH_CMP   = 2'b11
  } path_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff   = b_i ^ {W{sub_i}};
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o   = wide[W-1:0];
    carry_o = wide[W];
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
  end

  always_comb begin
    if (!sub_i && b_i == '0) begin
      AST_ADD_ZERO_IDENT: assert (sum_o == a_i && !carry_o && !ovf_o); // R1
    end
    if (sub_i && a_i == b_i) begin
      AST_SUB_SELF_ZERO: assert (sum_o == '0 && carry_o && !ovf_o); // R2
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] out_o
);
  import flag_alu_pkg::*;

  always_comb begin
    case (log_op_e'(op_i))
      LOG_AND: out_o = a_i & b_i;
      LOG_OR:  out_o = a_i | b_i;
      LOG_XOR: out_o = a_i ^ b_i;
      default: out_o = ~(a_i | b_i);
    endcase
  end

  always_comb begin
    if (op_i == LOG_XOR && a_i == b_i) begin
      AST_XOR_SELF_ZERO: assert (out_o == '0); // R3
    end
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  input  logic          arith_i,
  output logic [W-1:0]  out_o
);

  logic [W-1:0] src_rev;
  logic [W-1:0] stg [SW+1];
  logic [W-1:0] stg_rev;
  logic         fill;

  assign fill = right_i & arith_i & val_i[W-1];

  // Left shifts reuse the right-shift stages on bit-reversed data.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign src_rev[i] = val_i[W-1-i];
    assign stg_rev[i] = stg[SW][W-1-i];
  end

  assign stg[0] = right_i ? val_i : src_rev;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{SH{fill}}, stg[k][W-1:SH]} : stg[k];
  end

  assign out_o = right_i ? stg[SW] : stg_rev;

  always_comb begin
    if (amt_i == '0) begin
      AST_SHIFT_ZERO_PASS: assert (out_o == val_i); // R4
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W  = 32,
  parameter int FW = 5
) (
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic [FW-1:0] fn_i,
  output logic [W-1:0]  res_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o,
  output logic          n_o
);
  import flag_alu_pkg::*;

  localparam int SW = $clog2(W);

  alu_fn_t      fn;
  path_e        path;
  logic         sub_eff;
  logic [W-1:0] sum;
  logic         add_c;
  logic         add_v;
  logic [W-1:0] log_out;
  logic [W-1:0] shf_out;
  logic         lt_bit;

  assign fn      = alu_fn_t'(fn_i);
  assign path    = path_e'({fn.shft, fn.math});
  assign sub_eff = fn.sub | (fn.shft & fn.math);

  alu_addsub #(.W(W)) i_addsub (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .sub_i   (sub_eff),
    .sum_o   (sum),
    .carry_o (add_c),
    .ovf_o   (add_v)
  );

  alu_logic #(.W(W)) i_logic (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .op_i  (fn.sel),
    .out_o (log_out)
  );

  alu_shifter #(.W(W), .SW(SW)) i_shifter (
    .val_i   (op_b_i),
    .amt_i   (op_a_i[SW-1:0]),
    .right_i (fn.sel[1]),
    .arith_i (fn.sel[0]),
    .out_o   (shf_out)
  );

  assign lt_bit = fn.sel[0] ? (sum[W-1] ^ add_v) : ~add_c;

  always_comb begin
    case (path)
      PATH_ADDER: res_o = sum;
      PATH_SHIFT: res_o = shf_out;
      PATH_CMP:   res_o = {{(W-1){1'b0}}, lt_bit};
      default:    res_o = log_out;
    endcase
    v_o = fn.math & add_v;
    c_o = fn.math & add_c;
    z_o = ~|res_o;
    n_o = res_o[W-1];
  end

  always_comb begin
    if (path == PATH_CMP) begin
      AST_CMP_UPPER_ZERO: assert (res_o[W-1:1] == '0 && !n_o); // R5
    end
    if (!fn.math) begin
      AST_FLAGS_QUIET: assert (!v_o && !c_o); // R8
    end
    AST_Z_N_EXCLUSIVE: assert (!(z_o && n_o)); // R6
  end

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

  logic        clk;
  logic        rst_n;
  logic [31:0] a, b;
  logic [4:0]  fn;
  logic [31:0] res;
  logic        z, v, c, n;
  int          checks;
  int          errors;
  bit          done;

  localparam logic [4:0] F_ADD  = 5'b00001;
  localparam logic [4:0] F_SUB  = 5'b10001;
  localparam logic [4:0] F_AND  = 5'b00000;
  localparam logic [4:0] F_OR   = 5'b00100;
  localparam logic [4:0] F_XOR  = 5'b01000;
  localparam logic [4:0] F_NOR  = 5'b01100;
  localparam logic [4:0] F_SHL  = 5'b00010;
  localparam logic [4:0] F_SHL1 = 5'b00110;
  localparam logic [4:0] F_SHR  = 5'b01010;
  localparam logic [4:0] F_SRA  = 5'b01110;
  localparam logic [4:0] F_LTU  = 5'b00011;
  localparam logic [4:0] F_LT   = 5'b00111;

  flag_alu i_flag_alu (
    .op_a_i (a),
    .op_b_i (b),
    .fn_i   (fn),
    .res_o  (res),
    .z_o    (z),
    .v_o    (v),
    .c_o    (c),
    .n_o    (n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic ref_model(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y,
                           output logic [35:0] e);
    logic [32:0] t;
    logic [31:0] r;
    logic vv, cc;
    vv = 1'b0; cc = 1'b0; r = '0;
    t = {1'b0, x} + {1'b0, ~y} + 33'd1;
    if (f[1:0] == 2'b01 && !f[4]) begin
      t  = {1'b0, x} + {1'b0, y};
      r  = t[31:0]; cc = t[32];
      vv = (x[31] == y[31]) && (r[31] != x[31]);
    end else if (f[1:0] == 2'b01) begin
      r  = t[31:0]; cc = t[32];
      vv = (x[31] != y[31]) && (r[31] != x[31]);
    end else if (f[1:0] == 2'b11) begin
      cc = t[32];
      vv = (x[31] != y[31]) && (t[31] != x[31]);
      r  = f[2] ? {31'd0, $signed(x) < $signed(y)} : {31'd0, x < y};
    end else if (f[1:0] == 2'b10) begin
      case (f[3:2])
        2'b10:   r = y >> x[4:0];
        2'b11:   r = 32'($signed(y) >>> x[4:0]);
        default: r = y << x[4:0];
      endcase
    end else begin
      case (f[3:2])
        2'b00: r = x & y;
        2'b01: r = x | y;
        2'b10: r = x ^ y;
        default: r = ~(x | y);
      endcase
    end
    e = {r == 32'd0, vv, cc, r[31], r};
  endtask

  task automatic run_op(input string tag, input logic [4:0] f,
                        input logic [31:0] x, input logic [31:0] y);
    logic [35:0] exp;
    logic [35:0] act;
    @(posedge clk);
    #1;
    fn = f; a = x; b = y;
    @(negedge clk);
    ref_model(f, x, y, exp);
    act = {z, v, c, n, res};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fn=%b a=%h b=%h actual zvcn=%b res=%h expected zvcn=%b res=%h",
               tag, f, x, y, act[35:32], act[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic t_reset_state;
    run_op("R6 reset-zero", F_AND, 32'd0, 32'd0);
  endtask

  task automatic t_add;
    run_op("R1 add", F_ADD, 32'd5, 32'd7);
    run_op("R1 carry", F_ADD, 32'd1, 32'hFFFF_FFFF);
    run_op("R1 ovf", F_ADD, 32'h7FFF_FFFF, 32'd1);
    run_op("R1 neg-ovf", F_ADD, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub;
    run_op("R2 sub", F_SUB, 32'd9, 32'd4);
    run_op("R2 borrow", F_SUB, 32'd3, 32'd4);
    run_op("R2 ovf", F_SUB, 32'h8000_0000, 32'd1);
    run_op("R2 self", F_SUB, 32'h1234_5678, 32'h1234_5678);
  endtask

  task automatic t_logic;
    run_op("R3 and", F_AND, 32'hF0F0_1234, 32'hFF00_00FF);
    run_op("R3 or", F_OR, 32'hF0F0_1234, 32'h0F00_00FF);
    run_op("R3 xor", F_XOR, 32'hAAAA_5555, 32'hFFFF_0000);
    run_op("R3 nor", F_NOR, 32'h0000_FFFF, 32'h00FF_0000);
    run_op("R8 logic vc", F_NOR, 32'd0, 32'd0);
  endtask

  task automatic t_shift;
    run_op("R4 shl", F_SHL, 32'd4, 32'h8000_0001);
    run_op("R4 shl alias", F_SHL1, 32'd31, 32'd3);
    run_op("R4 shr", F_SHR, 32'd8, 32'h8000_FF00);
    run_op("R4 sra", F_SRA, 32'd8, 32'h8000_FF00);
    run_op("R4 sra pos", F_SRA, 32'd3, 32'h4000_0000);
    run_op("R4 amt high ignored", F_SHR, 32'hFFFF_FFE1, 32'h8000_0000);
    run_op("R4 zero amt", F_SRA, 32'hFFFF_FFE0, 32'hDEAD_BEEF);
    run_op("R8 shift vc", F_SHL, 32'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_compare;
    run_op("R5 lt signed", F_LT, 32'hFFFF_FFFF, 32'd1);
    run_op("R5 ltu", F_LTU, 32'hFFFF_FFFF, 32'd1);
    run_op("R5 ltu true", F_LTU, 32'd1, 32'hFFFF_FFFF);
    run_op("R5 lt ovf", F_LT, 32'h8000_0000, 32'h7FFF_FFFF);
    run_op("R5 equal", F_LT, 32'd42, 32'd42);
    run_op("R9 sub bit ignored", F_LT | 5'b10000, 32'h8000_0000, 32'h7FFF_FFFF);
    run_op("R9 sub bit ignored u", F_LTU | 5'b10000, 32'd2, 32'd3);
  endtask

  task automatic t_flags;
    run_op("R7 neg", F_OR, 32'h8000_0000, 32'd0);
    run_op("R6 zero", F_ADD, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 400; i++) begin
      run_op("R1-sweep", 5'(i % 32), $urandom, $urandom);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    a = '0; b = '0; fn = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_compare();
    t_flags();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule